// File: doc/BRIEF.md
# Egress Port Arbiter with Programmable Phase Table

This block sits on one virtual channel of a switch egress port and decides, once per cycle, which ingress port may send its next packet. Each ingress port raises a request line; the block answers with a registered grant naming one requesting port. Two schemes are available: a rotating-priority round robin across the ports, and a weighted round robin driven by a programmable phase table in which each entry names a port. Listing a port in more phases gives it a larger share.

Software fills a staging copy of the table, one entry per write, and then issues a load command. The block copies the staging table into the working table that the scheduler reads, one entry per cycle. While the copy runs no grants are issued. A status flag stays raised from the first table write until a copy that saw every write has finished. The arbitration scheme and the phase count are chosen with a 3-bit select value. It names a bit position in a fixed capability mask, and it takes effect when a load completes.

Top module: `egress_port_arbiter`

## Requirements
- R1: After reset no grant is issued, the table-status flag reads 0, the scheme is round robin, and port 0 holds the highest priority.
- R2: In round-robin mode the requesting port that comes first after the most recently granted port, in ascending order with wrap-around, is granted. The port granted last has the lowest priority on the next grant.
- R3: A table write stores only the low bits of the written value. The entry-size code in force during the write sets how many: code 0 keeps 1 bit, code 1 keeps 2 bits, code 2 keeps 4 bits and code 3 keeps 8 bits.
- R4: Every table write sets the table-status flag in the following cycle. The flag then stays set until a load copy finishes.
- R5: A control write whose load bit is 1 starts a copy of all MAX_PHASES staging entries into the working table, one per cycle. No grant is issued during the copy. The status flag is clear once the copy ends, unless a table write arrived during the copy. The select value held at the end of the copy becomes the active scheme, and the phase pointer restarts at phase 0.
- R6: A control write whose load bit is 0 starts no copy. It leaves the status flag and the active scheme unchanged.
- R7: The select value gives the phase count of weighted round robin: 1 means 32 phases, 2 means 64, 3 means 128 and 5 means 256. After each grant the phase pointer moves to the phase after the granted one, modulo the phase count.
- R8: In weighted round robin, phases whose port is not requesting are passed over within the same cycle. The grant goes to the first phase, counting from the pointer, whose port is requesting.
- R9: A select value whose capability bit is clear, or which names the time-based scheme (4) or a reserved position (6, 7), selects round robin.
- R10: A grant appears one cycle after the request it answers and always names a port that was requesting in that cycle. When at least one eligible port requests and no copy is running, exactly one grant is issued.
- R11: A table entry that names a port number at or above NUM_PORTS is never granted. Its phase is passed over like a non-requesting one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | NUM_PORTS | One request line per ingress port |
| tbl_wr | input | 1 | Write one staging table entry |
| tbl_idx | input | $clog2(MAX_PHASES) | Phase index of the entry being written |
| tbl_wdata | input | 8 | Port number to store (masked by entry size) |
| entry_sz | input | 2 | Entry-size code applied to table writes |
| ctrl_wr | input | 1 | Control write strobe (carries select and load bit) |
| ctrl_load | input | 1 | Load bit of the control write; 1 starts a copy |
| ctrl_sel | input | 3 | Scheme select, a bit position in the capability mask |
| tbl_pending | output | 1 | Table-status flag: staging table not yet applied |
| gnt_valid | output | 1 | A grant is issued this cycle |
| gnt_port | output | $clog2(NUM_PORTS) | Granted ingress port |

## Verification
The bench builds the block with six ports. Because this is not a power of two, table entries naming ports 6 and 7 exist but can never be granted, which exercises the pass-over rule for out-of-range entries. The capability mask is set to 0x2B, so the 64-phase select has its bit clear and must fall back to round robin, while the 32-, 128- and 256-phase variants remain reachable. MAX_PHASES stays at 256, so the full-length table and the complete copy window are exercised.

// File: rtl/egarb_pkg.sv
package egarb_pkg;

    typedef enum logic [2:0] {
        SEL_FIXED  = 3'd0,
        SEL_WRR32  = 3'd1,
        SEL_WRR64  = 3'd2,
        SEL_WRR128 = 3'd3,
        SEL_TBWRR  = 3'd4,
        SEL_WRR256 = 3'd5
    } arb_sel_e;

    localparam int ENTRY_W = 8;

    // Keep mask for an entry-size code: 1, 2, 4 or 8 low bits.
    function automatic logic [ENTRY_W-1:0] entry_mask(input logic [1:0] code);
        case (code)
            2'd0:    return 8'h01;
            2'd1:    return 8'h03;
            2'd2:    return 8'h0F;
            default: return 8'hFF;
        endcase
    endfunction

    // Phase count of a select value; 0 means round robin.
    function automatic int unsigned phase_count(input logic [2:0] sel,
                                                input logic [7:0] cap);
        if (!cap[sel]) return 0;
        case (sel)
            SEL_WRR32:  return 32;
            SEL_WRR64:  return 64;
            SEL_WRR128: return 128;
            SEL_WRR256: return 256;
            default:    return 0;
        endcase
    endfunction

endpackage

// File: rtl/egarb_store.sv
module egarb_store
    import egarb_pkg::*;
#(
    parameter int MAX_PHASES = 256,
    parameter int PHW        = 8
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 tbl_wr,
    input  logic [PHW-1:0]                       tbl_idx,
    input  logic [ENTRY_W-1:0]                   tbl_wdata,
    input  logic [1:0]                           entry_sz,
    input  logic                                 ctrl_wr,
    input  logic                                 ctrl_load,
    input  logic [2:0]                           ctrl_sel,
    output logic [MAX_PHASES-1:0][ENTRY_W-1:0]   act_tbl,
    output logic                                 copy_busy,
    output logic                                 apply_done,
    output logic [2:0]                           sel_hold,
    output logic                                 tbl_pending
);
    localparam logic [PHW-1:0] LAST_IDX = PHW'(MAX_PHASES - 1);

    typedef struct packed {
        logic [MAX_PHASES-1:0][ENTRY_W-1:0] shadow;
        logic [MAX_PHASES-1:0][ENTRY_W-1:0] active;
        logic                               busy;
        logic [PHW-1:0]                     cnt;
        logic                               redirty;
        logic                               pending;
        logic [2:0]                         sel;
    } store_t;

    store_t st_q, st_d;
    logic   done_c;

    always_comb begin
        st_d   = st_q;
        done_c = 1'b0;

        // Staging write: keep only the entry-width bits.
        if (tbl_wr) begin
            st_d.shadow[tbl_idx] = tbl_wdata & entry_mask(entry_sz);
            st_d.pending         = 1'b1;
            if (st_q.busy) st_d.redirty = 1'b1;
        end

        // Control write: select always captured, load bit 1 starts a copy.
        if (ctrl_wr) begin
            st_d.sel = ctrl_sel;
            if (ctrl_load && !st_q.busy) begin
                st_d.busy    = 1'b1;
                st_d.cnt     = '0;
                st_d.redirty = 1'b0;
            end
        end

        // Copy engine: one entry per cycle.
        if (st_q.busy) begin
            st_d.active[st_q.cnt] = st_q.shadow[st_q.cnt];
            st_d.cnt              = st_q.cnt + 1'b1;
            if (st_q.cnt == LAST_IDX) begin
                st_d.busy = 1'b0;
                done_c    = 1'b1;
                if (!st_q.redirty && !tbl_wr) st_d.pending = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign act_tbl     = st_q.active;
    assign copy_busy   = st_q.busy;
    assign apply_done  = done_c;
    assign sel_hold    = st_q.sel;
    assign tbl_pending = st_q.pending;

endmodule

// File: rtl/egarb_wrr_scan.sv
module egarb_wrr_scan
    import egarb_pkg::*;
#(
    parameter int NUM_PORTS  = 8,
    parameter int MAX_PHASES = 256,
    parameter int PHW        = 8,
    parameter int PW         = 3
) (
    input  logic [MAX_PHASES-1:0][ENTRY_W-1:0] tbl,
    input  logic [NUM_PORTS-1:0]               req,
    input  logic [PHW-1:0]                     ptr,
    input  logic [PHW-1:0]                     mask,
    output logic                               hit,
    output logic [PHW-1:0]                     phase,
    output logic [PW-1:0]                      port
);
    logic [MAX_PHASES-1:0] live;

    // A phase is live when its entry names an existing, requesting port.
    for (genvar g = 0; g < MAX_PHASES; g++) begin : g_live
        assign live[g] = (int'(tbl[g]) < NUM_PORTS) ? req[tbl[g][PW-1:0]] : 1'b0;
    end

    always_comb begin
        logic [PHW-1:0] idx;
        hit   = 1'b0;
        phase = '0;
        port  = '0;
        idx   = '0;
        for (int k = 0; k < MAX_PHASES; k++) begin
            idx = (ptr + PHW'(k)) & mask;
            if (!hit && ((PHW'(k) & ~mask) == '0) && live[idx]) begin
                hit   = 1'b1;
                phase = idx;
                port  = tbl[idx][PW-1:0];
            end
        end
    end

endmodule

// File: rtl/egarb_rr_scan.sv
module egarb_rr_scan #(
    parameter int NUM_PORTS = 8,
    parameter int PW        = 3
) (
    input  logic [NUM_PORTS-1:0] req,
    input  logic [PW-1:0]        last,
    output logic                 hit,
    output logic [PW-1:0]        port
);
    always_comb begin
        int p;
        hit  = 1'b0;
        port = '0;
        p    = 0;
        for (int k = 1; k <= NUM_PORTS; k++) begin
            p = (int'(last) + k) % NUM_PORTS;
            if (!hit && req[p]) begin
                hit  = 1'b1;
                port = PW'(p);
            end
        end
    end

endmodule

// File: rtl/egarb_sched.sv
module egarb_sched
    import egarb_pkg::*;
#(
    parameter int          NUM_PORTS  = 8,
    parameter int          MAX_PHASES = 256,
    parameter int          PHW        = 8,
    parameter int          PW         = 3,
    parameter logic [7:0]  CAP_MASK   = 8'h2F
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic [NUM_PORTS-1:0]               req,
    input  logic [MAX_PHASES-1:0][ENTRY_W-1:0] act_tbl,
    input  logic                               copy_busy,
    input  logic                               apply_done,
    input  logic [2:0]                         sel_hold,
    output logic                               gnt_valid,
    output logic [PW-1:0]                      gnt_port
);
    // Time-based slot timing is not built, so its capability bit is dropped.
    localparam logic [7:0] CAP_EFF = CAP_MASK & 8'hEF;

    typedef struct packed {
        logic           wrr;
        logic [PHW-1:0] mask;
        logic [PHW-1:0] ptr;
        logic [PW-1:0]  last;
        logic           gv;
        logic [PW-1:0]  gp;
    } sched_t;

    localparam sched_t SCHED_RST = '{
        wrr:  1'b0,
        mask: '0,
        ptr:  '0,
        last: PW'(NUM_PORTS - 1),
        gv:   1'b0,
        gp:   '0
    };

    sched_t sc_q, sc_d;

    logic           w_hit;
    logic [PHW-1:0] w_phase;
    logic [PW-1:0]  w_port;
    logic           r_hit;
    logic [PW-1:0]  r_port;

    egarb_wrr_scan #(
        .NUM_PORTS  (NUM_PORTS),
        .MAX_PHASES (MAX_PHASES),
        .PHW        (PHW),
        .PW         (PW)
    ) u_wrr (
        .tbl   (act_tbl),
        .req   (req),
        .ptr   (sc_q.ptr),
        .mask  (sc_q.mask),
        .hit   (w_hit),
        .phase (w_phase),
        .port  (w_port)
    );

    egarb_rr_scan #(
        .NUM_PORTS (NUM_PORTS),
        .PW        (PW)
    ) u_rr (
        .req  (req),
        .last (sc_q.last),
        .hit  (r_hit),
        .port (r_port)
    );

    always_comb begin
        int unsigned pc;
        sc_d    = sc_q;
        sc_d.gv = 1'b0;
        pc      = 0;

        if (!copy_busy) begin
            if (sc_q.wrr) begin
                if (w_hit) begin
                    sc_d.gv   = 1'b1;
                    sc_d.gp   = w_port;
                    sc_d.last = w_port;
                    sc_d.ptr  = (w_phase + 1'b1) & sc_q.mask;
                end
            end else if (r_hit) begin
                sc_d.gv   = 1'b1;
                sc_d.gp   = r_port;
                sc_d.last = r_port;
            end
        end

        // Scheme switch at the end of a copy.
        if (apply_done) begin
            pc       = phase_count(sel_hold, CAP_EFF);
            sc_d.ptr = '0;
            if (pc != 0 && pc <= MAX_PHASES) begin
                sc_d.wrr  = 1'b1;
                sc_d.mask = PHW'(pc - 1);
            end else begin
                sc_d.wrr  = 1'b0;
                sc_d.mask = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sc_q <= SCHED_RST;
        else        sc_q <= sc_d;
    end

    assign gnt_valid = sc_q.gv;
    assign gnt_port  = sc_q.gp;

endmodule

// File: rtl/egress_port_arbiter.sv
module egress_port_arbiter
    import egarb_pkg::*;
#(
    parameter int         NUM_PORTS  = 8,
    parameter int         MAX_PHASES = 256,
    parameter logic [7:0] CAP_MASK   = 8'h2F,
    localparam int        PHW        = $clog2(MAX_PHASES),
    localparam int        PW         = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_PORTS-1:0] req,
    input  logic                 tbl_wr,
    input  logic [PHW-1:0]       tbl_idx,
    input  logic [7:0]           tbl_wdata,
    input  logic [1:0]           entry_sz,
    input  logic                 ctrl_wr,
    input  logic                 ctrl_load,
    input  logic [2:0]           ctrl_sel,
    output logic                 tbl_pending,
    output logic                 gnt_valid,
    output logic [PW-1:0]        gnt_port
);
    logic [MAX_PHASES-1:0][ENTRY_W-1:0] act_tbl;
    logic                               copy_busy;
    logic                               apply_done;
    logic [2:0]                         sel_hold;

    egarb_store #(
        .MAX_PHASES (MAX_PHASES),
        .PHW        (PHW)
    ) u_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .tbl_wr      (tbl_wr),
        .tbl_idx     (tbl_idx),
        .tbl_wdata   (tbl_wdata),
        .entry_sz    (entry_sz),
        .ctrl_wr     (ctrl_wr),
        .ctrl_load   (ctrl_load),
        .ctrl_sel    (ctrl_sel),
        .act_tbl     (act_tbl),
        .copy_busy   (copy_busy),
        .apply_done  (apply_done),
        .sel_hold    (sel_hold),
        .tbl_pending (tbl_pending)
    );

    egarb_sched #(
        .NUM_PORTS  (NUM_PORTS),
        .MAX_PHASES (MAX_PHASES),
        .PHW        (PHW),
        .PW         (PW),
        .CAP_MASK   (CAP_MASK)
    ) u_sched (
        .clk        (clk),
        .rst_n      (rst_n),
        .req        (req),
        .act_tbl    (act_tbl),
        .copy_busy  (copy_busy),
        .apply_done (apply_done),
        .sel_hold   (sel_hold),
        .gnt_valid  (gnt_valid),
        .gnt_port   (gnt_port)
    );

endmodule

// File: rtl/egarb_checker.sv
module egarb_checker #(
    parameter int NUM_PORTS = 8,
    parameter int PW        = 3
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NUM_PORTS-1:0] req,
    input logic                 gnt_valid,
    input logic [PW-1:0]        gnt_port,
    input logic                 tbl_wr,
    input logic                 tbl_pending,
    input logic                 ctrl_wr,
    input logic                 ctrl_load,
    input logic                 copy_busy
);
    logic [NUM_PORTS-1:0] req_prev;

    always_ff @(posedge clk) begin
        if (!rst_n) req_prev <= '0;
        else        req_prev <= req;
    end

    AST_GNT_REQUESTED: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_valid |-> ((int'(gnt_port) < NUM_PORTS) && req_prev[gnt_port])); // R10
    AST_IDLE_NO_GNT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_prev == '0) |-> !gnt_valid); // R10
    AST_PORT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_valid |-> (int'(gnt_port) < NUM_PORTS)); // R11
    AST_WRITE_PENDS: assert property (@(posedge clk) disable iff (!rst_n)
        tbl_wr |=> tbl_pending); // R4
    AST_PEND_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (tbl_pending && !copy_busy) |=> tbl_pending); // R4
    AST_LOAD_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && ctrl_load && !copy_busy) |=> copy_busy); // R5
    AST_QUIET_APPLY: assert property (@(posedge clk) disable iff (!rst_n)
        copy_busy |=> !gnt_valid); // R5
    AST_ZERO_LOAD_NOP: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && !ctrl_load && !copy_busy) |=> !copy_busy); // R6

endmodule

bind egress_port_arbiter egarb_checker #(
    .NUM_PORTS (NUM_PORTS),
    .PW        (PW)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req         (req),
    .gnt_valid   (gnt_valid),
    .gnt_port    (gnt_port),
    .tbl_wr      (tbl_wr),
    .tbl_pending (tbl_pending),
    .ctrl_wr     (ctrl_wr),
    .ctrl_load   (ctrl_load),
    .copy_busy   (copy_busy)
);

// File: tb/egress_port_arbiter_test.sv
module egress_port_arbiter_test;
    localparam int         NP   = 6;
    localparam int         MAXP = 256;
    localparam logic [7:0] CAP  = 8'h2B;
    localparam int         PHW  = 8;
    localparam int         PW   = 3;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [NP-1:0]  req = '0;
    logic           tbl_wr = 1'b0;
    logic [PHW-1:0] tbl_idx = '0;
    logic [7:0]     tbl_wdata = '0;
    logic [1:0]     entry_sz = '0;
    logic           ctrl_wr = 1'b0;
    logic           ctrl_load = 1'b0;
    logic [2:0]     ctrl_sel = '0;
    logic           tbl_pending;
    logic           gnt_valid;
    logic [PW-1:0]  gnt_port;

    always #2 clk = ~clk;

    egress_port_arbiter #(
        .NUM_PORTS  (NP),
        .MAX_PHASES (MAXP),
        .CAP_MASK   (CAP)
    ) uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .req         (req),
        .tbl_wr      (tbl_wr),
        .tbl_idx     (tbl_idx),
        .tbl_wdata   (tbl_wdata),
        .entry_sz    (entry_sz),
        .ctrl_wr     (ctrl_wr),
        .ctrl_load   (ctrl_load),
        .ctrl_sel    (ctrl_sel),
        .tbl_pending (tbl_pending),
        .gnt_valid   (gnt_valid),
        .gnt_port    (gnt_port)
    );

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    int shadow [MAXP];
    int active [MAXP];
    int m_wrr  = 0;
    int m_cnt  = 0;
    int m_ptr  = 0;
    int m_last = NP - 1;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int sel_count(input int s);
        if (!CAP[s]) return 0;
        case (s)
            1: return 32;
            2: return 64;
            3: return 128;
            5: return 256;
            default: return 0;
        endcase
    endfunction

    // Drive one request vector for one cycle and check the registered grant.
    task automatic step(input logic [NP-1:0] r, input string tag);
        int ep;
        int eph;
        bit found;
        ep = -1; eph = -1; found = 1'b0;
        req = r;
        @(negedge clk);
        if (m_wrr != 0) begin
            for (int k = 0; k < m_cnt; k++) begin
                int idx;
                idx = (m_ptr + k) % m_cnt;
                if (!found && active[idx] < NP && r[active[idx]]) begin
                    found = 1'b1; ep = active[idx]; eph = idx;
                end
            end
        end else begin
            for (int k = 1; k <= NP; k++) begin
                int p;
                p = (m_last + k) % NP;
                if (!found && r[p]) begin
                    found = 1'b1; ep = p;
                end
            end
        end
        check(gnt_valid == found, tag, int'(gnt_valid), int'(found));
        if (found) begin
            check(int'(gnt_port) == ep, tag, int'(gnt_port), ep);
            m_last = ep;
            if (m_wrr != 0) m_ptr = (eph + 1) % m_cnt;
        end
    endtask

    task automatic wr_entry(input int idx, input int data, input int sz);
        tbl_wr    = 1'b1;
        tbl_idx   = PHW'(idx);
        tbl_wdata = 8'(data);
        entry_sz  = 2'(sz);
        step('0, "R4 write cycle");
        tbl_wr = 1'b0;
        shadow[idx] = data & ((1 << (1 << sz)) - 1);
        check(tbl_pending == 1'b1, "R4 status set", int'(tbl_pending), 1);
    endtask

    task automatic do_load(input int sel);
        int bad;
        bit was_pending;
        was_pending = tbl_pending;
        ctrl_wr = 1'b1; ctrl_load = 1'b1; ctrl_sel = 3'(sel);
        step('0, "R5 load cycle");
        ctrl_wr = 1'b0; ctrl_load = 1'b0;
        bad = 0;
        for (int i = 0; i < MAXP; i++) begin
            req = '1;
            @(negedge clk);
            if (gnt_valid) bad++;
            if (i == 100 && was_pending)
                check(tbl_pending == 1'b1, "R4 status during copy", int'(tbl_pending), 1);
        end
        req = '0;
        check(bad == 0, "R5 no grant during copy", bad, 0);
        check(tbl_pending == 1'b0, "R5 status cleared", int'(tbl_pending), 0);
        for (int i = 0; i < MAXP; i++) active[i] = shadow[i];
        m_cnt = sel_count(sel);
        m_wrr = (m_cnt != 0) ? 1 : 0;
        m_ptr = 0;
    endtask

    task automatic ctrl_zero_load(input int sel);
        logic pend;
        pend = tbl_pending;
        ctrl_wr = 1'b1; ctrl_load = 1'b0; ctrl_sel = 3'(sel);
        step(NP'($urandom), "R6 load bit 0");
        ctrl_wr = 1'b0;
        check(tbl_pending == pend, "R6 status unchanged", int'(tbl_pending), int'(pend));
    endtask

    task automatic rand_run(input int n, input string tag);
        for (int i = 0; i < n; i++) step(NP'($urandom), tag);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < MAXP; i++) begin shadow[i] = 0; active[i] = 0; end
        repeat (3) @(negedge clk);
        check(gnt_valid == 1'b0, "R1 no grant in reset", int'(gnt_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(gnt_valid == 1'b0, "R1 no grant after reset", int'(gnt_valid), 0);
        check(tbl_pending == 1'b0, "R1 status clear", int'(tbl_pending), 0);

        // Round robin: port 0 first, then rotation.
        step('1, "R1 port 0 first");
        for (int i = 0; i < 8; i++) step('1, "R2 rotation all requesting");
        step(6'b001000, "R2 single requester");
        step(6'b001001, "R2 last granted lowest");
        step(6'b001001, "R2 wrap to lower port");
        rand_run(300, "R10 random round robin");

        // Entry widths: phase 0..4 directed, rest of 32 random.
        wr_entry(0, 8'hFF, 0);
        wr_entry(1, 8'hFE, 1);
        wr_entry(2, 8'h35, 2);
        wr_entry(3, 8'h07, 3);
        wr_entry(4, 8'h03, 3);
        for (int i = 5; i < 32; i++) wr_entry(i, int'($urandom % 256), int'($urandom % 4));
        do_load(1);
        step('1, "R3 one-bit entry gives port 1");
        step('1, "R3 two-bit entry gives port 2");
        step('1, "R3 four-bit entry gives port 5");
        step('1, "R11 port 7 entry passed over");
        step(6'b001000, "R8 skip to requesting phase");
        rand_run(200, "R7 random 32 phases");

        ctrl_zero_load(5);
        rand_run(100, "R6 scheme unchanged");

        for (int i = 0; i < MAXP; i++) wr_entry(i, int'($urandom % 256), int'($urandom % 4));
        do_load(5);
        rand_run(400, "R7 random 256 phases");
        step('1, "R8 all requesting 256");

        for (int i = 0; i < 128; i++) wr_entry(i, int'($urandom % 8), 3);
        do_load(3);
        rand_run(300, "R7 random 128 phases");

        do_load(2);
        for (int i = 0; i < 8; i++) step('1, "R9 capability bit clear");
        do_load(4);
        for (int i = 0; i < 7; i++) step('1, "R9 time-based select");
        do_load(7);
        rand_run(100, "R9 reserved select");
        do_load(1);
        rand_run(150, "R11 random 32 phases after reload");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule